// File: doc/BRIEF.md
# Inverted Page Table Chain Walker

This block turns a virtual page number and an address-space identifier into a physical frame number. The translation table is inverted: it holds one entry for each physical frame, and each entry names the virtual page that currently lives in that frame. The block folds the page number and the identifier into a short index. It uses that index to read a head pointer from an anchor table. It then follows the linked entries one memory read at a time until an entry matches the request or the chain ends.

The walker issues every read through a single memory read port and waits for the reply, so the reply may arrive after any number of cycles. Two base inputs give the start of the anchor table and the start of the frame table. Each table entry takes one memory word. When an entry matches, the index of that entry is the frame number. The walker then returns the physical address, which is that frame number with the page offset placed below it. When there is no match, it reports a page fault. A step budget ends the walk if the chain turns out to be cyclic.

Top module: `ipt_lookup`

## Requirements
- R1: After reset `req_ready` is 1, `resp_valid` is 0 and `mem_req` is 0, and no read is issued while the walker is idle.
- R2: The first read of a lookup goes to `hat_base + idx`. To form `idx`, split the page number into a low half of ceil(VPN_W/2) bits and a high half made of the remaining bits. XOR the two halves with the ASID, all zero-extended. Cut the result into HAT_W-bit chunks starting from the LSB and XOR the chunks together.
- R3: Each chain read goes to `ipt_base + ptr`. The word layout is: bits [FW-1:0] the next pointer, then VPN_W bits holding the page number, then ASID_W bits holding the ASID, then one valid bit at the top. An anchor word keeps its head pointer in bits [FW-1:0].
- R4: A hit needs the entry's valid bit set and both its page number and its ASID equal to the request. The returned frame is the index of that entry. Entries with the same page number under a different ASID do not match.
- R5: An entry whose tags match but whose valid bit is 0 is passed over, and the walk follows its next pointer.
- R6: A pointer value of NUM_FRAMES or more ends the chain. All ones is such a value. If the anchor holds one, the walker faults after that single read. If a next pointer holds one and its entry did not match, the walker also faults.
- R7: On a hit `resp_paddr` = {frame, offset}. On a fault `resp_frame` and `resp_paddr` are both 0.
- R8: If NUM_FRAMES entries are read without a hit, the walk stops with a fault. That lookup makes NUM_FRAMES+1 reads in total.
- R9: Each read is a single-cycle `mem_req` pulse. The walker waits for `mem_rvalid` before it goes on, whatever the reply latency.
- R10: `req_ready` is 0 from the accepting cycle until the result. `resp_valid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A lookup request is present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vpn | input | VPN_W | Virtual page number |
| req_asid | input | ASID_W | Address-space identifier |
| req_offset | input | OFF_W | Offset within the page |
| hat_base | input | ADDR_W | Word address of the anchor table |
| ipt_base | input | ADDR_W | Word address of the frame table |
| mem_req | output | 1 | Read strobe, one cycle per read |
| mem_addr | output | ADDR_W | Read word address |
| mem_rvalid | input | 1 | Read data is valid |
| mem_rdata | input | WORD_W | Read data word |
| resp_valid | output | 1 | Result pulse |
| resp_fault | output | 1 | Page fault flag |
| resp_frame | output | FW | Matching frame number |
| resp_paddr | output | FW+OFF_W | Physical address |

## Verification
The case hardest to reach from the ports is the step budget. A correct table never makes the walker use the whole budget, so the bench plants an entry whose next pointer points back to itself and whose page number differs from the request. It then counts the memory strobes and expects exactly NUM_FRAMES+1 reads before the fault. A second case that needs care is a chain that holds the same page number under a second ASID and also as an invalid entry. For that case the bench builds chains in which the wrong candidates come before the right one, so the frame that comes back shows that they were passed over. The bench also slows one reply down by several cycles.

// File: rtl/ipt_pkg.sv
package ipt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ANCHOR_RD,
        ST_ANCHOR_WT,
        ST_ENTRY_RD,
        ST_ENTRY_WT
    } walk_state_e;

    typedef enum logic [1:0] {
        STEP_WAIT,
        STEP_ADVANCE,
        STEP_HIT,
        STEP_FAULT
    } step_verdict_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ipt_hash.sv
module ipt_hash #(
    parameter int VPN_W  = 16,
    parameter int ASID_W = 8,
    parameter int HAT_W  = 5
) (
    input  logic [VPN_W-1:0]  vpn,
    input  logic [ASID_W-1:0] asid,
    output logic [HAT_W-1:0]  idx
);
    import ipt_pkg::*;

    localparam int LO_W = (VPN_W + 1) / 2;
    localparam int HI_W = VPN_W - LO_W;
    localparam int MIX_W = int'(max2(LO_W, ASID_W));
    localparam int NCH = (MIX_W + HAT_W - 1) / HAT_W;
    localparam int PAD_W = NCH * HAT_W;

    logic [LO_W-1:0]  lo_half;
    logic [HI_W-1:0]  hi_half;
    logic [PAD_W-1:0] mixed;
    logic [HAT_W-1:0] chunk [NCH];

    assign lo_half = vpn[LO_W-1:0];
    assign hi_half = vpn[VPN_W-1:LO_W];
    assign mixed   = PAD_W'(lo_half) ^ PAD_W'(hi_half) ^ PAD_W'(asid);

    for (genvar c = 0; c < NCH; c++) begin : g_chunk
        assign chunk[c] = mixed[c*HAT_W +: HAT_W];
    end

    always_comb begin
        idx = '0;
        for (int c = 0; c < NCH; c++) begin
            idx = idx ^ chunk[c];
        end
    end

endmodule

// File: rtl/ipt_entry_match.sv
module ipt_entry_match #(
    parameter int FW         = 6,
    parameter int VPN_W      = 16,
    parameter int ASID_W     = 8,
    parameter int NUM_FRAMES = 63,
    parameter int WORD_W     = FW + VPN_W + ASID_W + 1
) (
    input  logic [WORD_W-1:0] word,
    input  logic [VPN_W-1:0]  key_vpn,
    input  logic [ASID_W-1:0] key_asid,
    output logic              hit,
    output logic [FW-1:0]     next_ptr,
    output logic              chain_end
);
    localparam int VPN_LSB  = FW;
    localparam int ASID_LSB = FW + VPN_W;
    localparam int VLD_BIT  = FW + VPN_W + ASID_W;

    typedef struct packed {
        logic              valid;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [FW-1:0]     nxt;
    } entry_t;

    entry_t ent;
    logic   vpn_eq;
    logic   asid_eq;

    assign ent.valid = word[VLD_BIT];
    assign ent.asid  = word[ASID_LSB +: ASID_W];
    assign ent.vpn   = word[VPN_LSB +: VPN_W];
    assign ent.nxt   = word[FW-1:0];

    assign vpn_eq    = (ent.vpn == key_vpn);
    assign asid_eq   = (ent.asid == key_asid);
    assign hit       = ent.valid && vpn_eq && asid_eq;
    assign next_ptr  = ent.nxt;
    assign chain_end = (ent.nxt >= FW'(NUM_FRAMES));

endmodule

// File: rtl/ipt_step_guard.sv
module ipt_step_guard #(
    parameter int NUM_FRAMES = 63
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic advance,
    output logic last_step
);
    localparam int SW = $clog2(NUM_FRAMES + 1);

    logic [SW-1:0] steps;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            steps <= '0;
        end else if (advance) begin
            steps <= steps + 1'b1;
        end
    end

    assign last_step = (steps == SW'(NUM_FRAMES - 1));

endmodule

// File: rtl/ipt_lookup.sv
module ipt_lookup #(
    parameter int NUM_FRAMES = 63,
    parameter int VPN_W      = 16,
    parameter int ASID_W     = 8,
    parameter int HAT_W      = 5,
    parameter int OFF_W      = 12,
    parameter int ADDR_W     = 16,
    parameter int FW         = $clog2(NUM_FRAMES + 1),
    parameter int WORD_W     = FW + VPN_W + ASID_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VPN_W-1:0]  req_vpn,
    input  logic [ASID_W-1:0] req_asid,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic [ADDR_W-1:0] hat_base,
    input  logic [ADDR_W-1:0] ipt_base,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              resp_valid,
    output logic              resp_fault,
    output logic [FW-1:0]     resp_frame,
    output logic [FW+OFF_W-1:0] resp_paddr
);
    import ipt_pkg::*;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [OFF_W-1:0]  off;
    } lookup_t;

    walk_state_e   state;
    lookup_t       cur;
    logic [FW-1:0] ptr;
    logic [HAT_W-1:0] anchor_idx;
    logic          ent_hit;
    logic [FW-1:0] ent_next;
    logic          ent_end;
    logic          guard_last;
    logic          accept;
    step_verdict_e verdict;

    assign accept    = (state == ST_IDLE) && req_valid;
    assign req_ready = (state == ST_IDLE);

    ipt_hash #(
        .VPN_W (VPN_W),
        .ASID_W(ASID_W),
        .HAT_W (HAT_W)
    ) u_hash (
        .vpn (cur.vpn),
        .asid(cur.asid),
        .idx (anchor_idx)
    );

    ipt_entry_match #(
        .FW        (FW),
        .VPN_W     (VPN_W),
        .ASID_W    (ASID_W),
        .NUM_FRAMES(NUM_FRAMES),
        .WORD_W    (WORD_W)
    ) u_match (
        .word     (mem_rdata),
        .key_vpn  (cur.vpn),
        .key_asid (cur.asid),
        .hit      (ent_hit),
        .next_ptr (ent_next),
        .chain_end(ent_end)
    );

    ipt_step_guard #(
        .NUM_FRAMES(NUM_FRAMES)
    ) u_guard (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept),
        .advance  (verdict == STEP_ADVANCE && state == ST_ENTRY_WT),
        .last_step(guard_last)
    );

    always_comb begin
        verdict = STEP_WAIT;
        if (mem_rvalid) begin
            if (state == ST_ANCHOR_WT) begin
                verdict = ent_end ? STEP_FAULT : STEP_ADVANCE;
            end else if (state == ST_ENTRY_WT) begin
                if (ent_hit) begin
                    verdict = STEP_HIT;
                end else if (ent_end || guard_last) begin
                    verdict = STEP_FAULT;
                end else begin
                    verdict = STEP_ADVANCE;
                end
            end
        end
    end

    assign mem_req  = (state == ST_ANCHOR_RD) || (state == ST_ENTRY_RD);
    assign mem_addr = (state == ST_ANCHOR_RD) ? (hat_base + ADDR_W'(anchor_idx))
                                              : (ipt_base + ADDR_W'(ptr));

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cur        <= '0;
            ptr        <= '0;
            resp_valid <= 1'b0;
            resp_fault <= 1'b0;
            resp_frame <= '0;
            resp_paddr <= '0;
        end else begin
            resp_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur.vpn  <= req_vpn;
                        cur.asid <= req_asid;
                        cur.off  <= req_offset;
                        state    <= ST_ANCHOR_RD;
                    end
                end
                ST_ANCHOR_RD: state <= ST_ANCHOR_WT;
                ST_ENTRY_RD:  state <= ST_ENTRY_WT;
                ST_ANCHOR_WT, ST_ENTRY_WT: begin
                    case (verdict)
                        STEP_ADVANCE: begin
                            ptr   <= ent_next;
                            state <= ST_ENTRY_RD;
                        end
                        STEP_HIT: begin
                            resp_valid <= 1'b1;
                            resp_fault <= 1'b0;
                            resp_frame <= ptr;
                            resp_paddr <= {ptr, cur.off};
                            state      <= ST_IDLE;
                        end
                        STEP_FAULT: begin
                            resp_valid <= 1'b1;
                            resp_fault <= 1'b1;
                            resp_frame <= '0;
                            resp_paddr <= '0;
                            state      <= ST_IDLE;
                        end
                        default: ;
                    endcase
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ipt_lookup_chk.sv
module ipt_lookup_chk #(
    parameter int NUM_FRAMES = 63,
    parameter int OFF_W      = 12,
    parameter int FW         = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [OFF_W-1:0]  req_offset,
    input logic              mem_req,
    input logic              resp_valid,
    input logic              resp_fault,
    input logic [FW-1:0]     resp_frame,
    input logic [FW+OFF_W-1:0] resp_paddr
);
    logic [OFF_W-1:0] off_seen;
    logic [15:0]      reads;

    always_ff @(posedge clk) begin
        if (rst) begin
            off_seen <= '0;
            reads    <= '0;
        end else if (req_valid && req_ready) begin
            off_seen <= req_offset;
            reads    <= '0;
        end else if (mem_req) begin
            reads <= reads + 16'd1;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_req);

    assert_frame_range_R4: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_fault) |-> (resp_frame < FW'(NUM_FRAMES)));

    assert_hit_paddr_R7: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_fault) |->
            (resp_paddr == {resp_frame, off_seen}));

    assert_fault_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_fault) |-> (resp_frame == '0 && resp_paddr == '0));

    assert_read_budget_R8: assert property (@(posedge clk) disable iff (rst)
        reads <= 16'(NUM_FRAMES + 1));

    assert_strobe_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_resp_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);

endmodule

bind ipt_lookup ipt_lookup_chk #(
    .NUM_FRAMES(NUM_FRAMES),
    .OFF_W     (OFF_W),
    .FW        (FW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_offset(req_offset),
    .mem_req   (mem_req),
    .resp_valid(resp_valid),
    .resp_fault(resp_fault),
    .resp_frame(resp_frame),
    .resp_paddr(resp_paddr)
);

// File: tb/sim_ipt_lookup.sv
module sim_ipt_lookup;

    localparam int CLK_PERIOD = 10;
    localparam int NF = 63;
    localparam int WW = 31;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_vpn = '0;
    logic [7:0]  req_asid = '0;
    logic [11:0] req_offset = '0;
    logic [15:0] hat_base = 16'h0010;
    logic [15:0] ipt_base = 16'h0080;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [WW-1:0] mem_rdata = '0;
    logic        resp_valid;
    logic        resp_fault;
    logic [5:0]  resp_frame;
    logic [17:0] resp_paddr;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ipt_lookup u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vpn(req_vpn), .req_asid(req_asid), .req_offset(req_offset),
        .hat_base(hat_base), .ipt_base(ipt_base),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .resp_valid(resp_valid), .resp_fault(resp_fault),
        .resp_frame(resp_frame), .resp_paddr(resp_paddr)
    );

    // memory model with adjustable reply delay
    logic [WW-1:0] mem [256];
    int   lat = 0;
    logic pend = 1'b0;
    int   wcnt = 0;
    logic [7:0] a_q = '0;
    int   rd_cnt = 0;
    logic [15:0] first_addr = '0;
    logic [15:0] last_addr = '0;

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_req) begin
            pend <= 1'b1;
            wcnt <= lat;
            a_q  <= mem_addr[7:0];
        end else if (pend) begin
            if (wcnt == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem[a_q];
                pend       <= 1'b0;
            end else begin
                wcnt <= wcnt - 1;
            end
        end
        if (req_valid && req_ready) begin
            rd_cnt <= 0;
        end else if (mem_req) begin
            if (rd_cnt == 0) first_addr <= mem_addr;
            last_addr <= mem_addr;
            rd_cnt <= rd_cnt + 1;
        end
    end

    function automatic logic [WW-1:0] ent(input logic v, input logic [7:0] asid,
                                          input logic [15:0] vpn, input logic [5:0] nxt);
        return {v, asid, vpn, nxt};
    endfunction

    task automatic check(input logic ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic [15:0] vpn;
        logic [7:0]  asid;
        logic [11:0] off;
        logic        fault;
        logic [5:0]  frame;
        logic [6:0]  reads;
        logic [4:0]  idx;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{16'h0003, 8'h00, 12'h123, 1'b0, 6'd10, 7'd2,  5'd3},
        '{16'h0100, 8'h02, 12'hABC, 1'b0, 6'd20, 7'd3,  5'd3},
        '{16'h0003, 8'h21, 12'hFFF, 1'b0, 6'd7,  7'd4,  5'd3},
        '{16'h0003, 8'h42, 12'h000, 1'b1, 6'd0,  7'd4,  5'd3},
        '{16'h0009, 8'h00, 12'h555, 1'b0, 6'd31, 7'd3,  5'd9},
        '{16'h000C, 8'h00, 12'h001, 1'b1, 6'd0,  7'd1,  5'd12},
        '{16'h0014, 8'h00, 12'h777, 1'b0, 6'd0,  7'd2,  5'd20},
        '{16'h2114, 8'h00, 12'h888, 1'b0, 6'd62, 7'd3,  5'd20},
        '{16'h4214, 8'h00, 12'h999, 1'b1, 6'd0,  7'd3,  5'd20},
        '{16'h0011, 8'h00, 12'h010, 1'b1, 6'd0,  7'd64, 5'd17}
    };

    task automatic run_vec(input vec_t v, input string tag);
        int n;
        @(negedge clk);
        req_valid  = 1'b1;
        req_vpn    = v.vpn;
        req_asid   = v.asid;
        req_offset = v.off;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, {tag, " R10 busy"}, req_ready, 0);
        n = 0;
        while (!resp_valid && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(resp_valid == 1'b1, {tag, " timeout"}, resp_valid, 1);
        check(resp_fault == v.fault, {tag, " R4/R6 fault"}, resp_fault, v.fault);
        check(resp_frame == v.frame, {tag, " R4 frame"}, resp_frame, v.frame);
        check(resp_paddr == (v.fault ? 18'd0 : {v.frame, v.off}), {tag, " R7 paddr"},
              resp_paddr, v.fault ? 0 : {v.frame, v.off});
        check(rd_cnt == int'(v.reads), {tag, " R8/R9 reads"}, rd_cnt, v.reads);
        check(first_addr == 16'h0010 + 16'(v.idx), {tag, " R2 anchor addr"},
              first_addr, 16'h0010 + 16'(v.idx));
        if (!v.fault)
            check(last_addr == 16'h0080 + 16'(v.frame), {tag, " R3 entry addr"},
                  last_addr, 16'h0080 + 16'(v.frame));
        @(negedge clk);
        check(resp_valid == 1'b0 && req_ready == 1'b1, {tag, " R10 pulse"}, resp_valid, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        for (int i = 0; i < 32; i++) mem[16 + i] = WW'(6'h3F);
        mem[16 + 3]  = WW'(6'd10);
        mem[16 + 9]  = WW'(6'd30);
        mem[16 + 17] = WW'(6'd40);
        mem[16 + 20] = WW'(6'd0);
        mem[128 + 10] = ent(1'b1, 8'h00, 16'h0003, 6'd20);
        mem[128 + 20] = ent(1'b1, 8'h02, 16'h0100, 6'd7);
        mem[128 + 7]  = ent(1'b1, 8'h21, 16'h0003, 6'h3F);
        mem[128 + 30] = ent(1'b0, 8'h00, 16'h0009, 6'd31);
        mem[128 + 31] = ent(1'b1, 8'h00, 16'h0009, 6'h3F);
        mem[128 + 40] = ent(1'b1, 8'h00, 16'hFFFF, 6'd40);
        mem[128 + 0]  = ent(1'b1, 8'h00, 16'h0014, 6'd62);
        mem[128 + 62] = ent(1'b1, 8'h00, 16'h2114, 6'h3F);

        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
        check(resp_valid == 1'b0, "R1 reset resp", resp_valid, 0);
        check(mem_req == 1'b0, "R1 reset mem_req", mem_req, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(mem_req == 1'b0, "R1 idle no read", mem_req, 0);

        // R2 R3 R4 R5 R6 R7 R8 table walk
        for (int k = 0; k < NV; k++) begin
            run_vec(VECS[k], $sformatf("vec%0d", k));
        end

        // R9: slow memory replies still give the same result
        lat = 4;
        run_vec(VECS[2], "R9 slow reply");
        lat = 0;

        // R2 R3: moved tables, same contents reached through new bases
        for (int i = 0; i < 32; i++) mem[64 + i] = mem[16 + i];
        for (int i = 0; i < 64; i++) mem[192 + i] = mem[128 + i];
        hat_base = 16'h0040;
        ipt_base = 16'h00C0;
        begin
            int n;
            @(negedge clk);
            req_valid = 1'b1; req_vpn = 16'h0009; req_asid = 8'h00; req_offset = 12'h0AA;
            @(negedge clk);
            req_valid = 1'b0;
            n = 0;
            while (!resp_valid && n < 2000) begin @(negedge clk); n++; end
            check(resp_frame == 6'd31 && !resp_fault, "R3 rebased frame", resp_frame, 31);
            check(first_addr == 16'h0049, "R2 rebased anchor", first_addr, 16'h0049);
            check(last_addr == 16'h00DF, "R3 rebased entry", last_addr, 16'h00DF);
        end

        // R1: synchronous reset mid-walk returns to idle
        @(negedge clk);
        req_valid = 1'b1; req_vpn = 16'h0011; req_asid = 8'h00;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (10) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && mem_req == 1'b0 && resp_valid == 1'b0,
              "R1 reset mid-walk", {req_ready, mem_req, resp_valid}, 3'b100);
        rst = 1'b0;
        repeat (6) @(negedge clk);
        check(mem_req == 1'b0 && resp_valid == 1'b0, "R1 quiet after reset",
              {mem_req, resp_valid}, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule